// File: doc/BRIEF.md
# Fixed-Frequency PWM Switch Controller

This block is the digital pulse-width modulator for an off-line power switch. A phase counter runs at a fixed switching period (100 kHz by default, taken from the system clock rate). Each cycle starts with the gate command on, and the modulator turns it off once the on-time for that cycle has run out. An unsigned control code stands for the feedback current. A higher code gives a shorter pulse. The on-time is never longer than a hard maximum duty and never shorter than a minimum on-time.

A current-limit comparator flag can end a pulse early. It is ignored for a blanking interval after turn-on, so that turn-on spikes cannot cut the pulse. Once the pulse ends, the switch stays off until the next cycle begins. A run enable from the supervisor can cut a pulse at any point, but it can only start a pulse again at a cycle boundary. The control code is taken once per cycle, at the boundary. An end-of-cycle strobe marks the last clock of every period.

Top module: `pwm_switch_ctrl`

## Requirements
- R1: The period is PERIOD = CLK_HZ/SW_HZ clocks (500 by default). `cycle_end` is high for exactly one clock, the last clock of each period. The first period begins on the first clock edge after reset is released. While reset is held, `gate_drv` and `cycle_end` are low.
- R2: `gate_drv` rises only on the first clock of a period. It makes at most one contiguous pulse per period.
- R3: `ctrl_code` is sampled only at the period start. A change in the middle of a period has no effect on that period's pulse and applies from the next period.
- R4: For a code at or below KNEE (25), the pulse lasts MAX_ON = PERIOD*67/100 clocks (335 by default).
- R5: For a code above KNEE, the pulse lasts MAX_ON - (code - KNEE)*SLOPE clocks, with SLOPE = 8 by default. For example, code 26 gives 327 and code 50 gives 135.
- R6: The pulse is never shorter than MIN_ON = PERIOD*15/1000 clocks (7 by default) and never longer than MAX_ON. Codes 66 and 255 both give 7.
- R7: When `ilim_trip` is sampled high on the clock edge that ends on-clock p (counting from p = 0), and p >= GUARD-1, the pulse lasts p+1 clocks. The gate then stays low for the rest of the period, even after the flag drops.
- R8: GUARD = max(BLANK, MIN_ON), which is 10 by default. `ilim_trip` samples taken on the first GUARD-1 edges of a pulse are ignored. A flag held high for the whole period gives a pulse of GUARD clocks, or the law's length if that is shorter.
- R9: When `run_en` is sampled low at on-clock p, the pulse lasts p+1 clocks. Raising `run_en` again in the same period does not restart the pulse. If `run_en` is low at the period start, there is no pulse in that period. The next period with `run_en` high produces a normal pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_code | input | CODE_W (8) | Feedback level; a higher value gives a shorter pulse |
| ilim_trip | input | 1 | Current-limit comparator flag |
| run_en | input | 1 | Supervisor run enable |
| gate_drv | output | 1 | Switch gate command |
| cycle_end | output | 1 | One-clock strobe on the last clock of each period |

## Verification
Every input reaches the outputs through one register. The code, the run enable and the current-limit flag sampled on the edge at phase p first show on `gate_drv` at phase p+1. The period-start values show at phase 0, and `cycle_end` rises one clock after phase PERIOD-2. The driver therefore sets the inputs on the falling edge ahead of the edge at which they are meant to be sampled, and queues the pulse length that the requirements give for that period. The monitor samples the outputs on falling edges, counts the high gate clocks between strobes, and compares the count when the strobe clock arrives. This ties each result to the exact period that produced it.

// File: rtl/pwm_pkg.sv
// Package: shared arithmetic helpers for the PWM switch controller.
// Assumes all arguments are small non-negative integers known at elaboration.
package pwm_pkg;

    // Scale a total by num/den, truncating toward zero.
    function automatic int scale_frac(input int total, input int num, input int den);
        return (total * num) / den;
    endfunction

    // Larger of two integers.
    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwm_sawtooth.sv
// Module: pwm_sawtooth
// Phase counter that acts as the digital sawtooth. It counts 0..PERIOD-1 and
// marks the wrap point. During reset it parks on the last phase, so the first
// edge after release starts a fresh period. It also drives a registered strobe
// that is high on the last phase.
// Assumes PERIOD >= 3.
module pwm_sawtooth #(
    parameter int PERIOD = 500,
    parameter int PH_W   = $clog2(PERIOD)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            wrap,
    output logic            last_strobe
);
    localparam logic [PH_W-1:0] LAST     = PH_W'(PERIOD - 1);
    localparam logic [PH_W-1:0] PRE_LAST = PH_W'(PERIOD - 2);

    logic [PH_W-1:0] ph_q;
    logic            strobe_q;

    // Wrap is the last phase: the next edge starts a new period.
    assign wrap        = (ph_q == LAST);
    assign phase       = ph_q;
    assign last_strobe = strobe_q;

    // Advance the phase, wrapping to zero after the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= LAST;
        end else if (wrap) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    // Register the end-of-period strobe so that it is high on the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= (ph_q == PRE_LAST);
        end
    end

    // R1: the strobe appears only on the last phase.
    a_r1_strobe_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |-> (ph_q == LAST));

    // R1: the strobe lasts a single clock.
    a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |=> !strobe_q);

endmodule

// File: rtl/pwm_duty_law.sv
// Module: pwm_duty_law
// Maps the control code to the on-time in clocks. At or below the knee it
// gives the maximum; above the knee it subtracts SLOPE clocks per code step,
// and it never goes below the minimum on-time. The result is latched only at
// the period boundary.
// Assumes MAX_ON > MIN_ON >= 1 and code*SLOPE fits in 32 bits.
module pwm_duty_law #(
    parameter int CODE_W = 8,
    parameter int MAX_ON = 335,
    parameter int MIN_ON = 7,
    parameter int KNEE   = 25,
    parameter int SLOPE  = 8,
    parameter int LEN_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code,
    output logic [LEN_W-1:0]  on_len
);
    localparam int SPAN = MAX_ON - MIN_ON;

    logic [31:0]      excess;
    logic [31:0]      cut;
    logic [LEN_W-1:0] len_d;
    logic [LEN_W-1:0] len_q;

    // Compute the clamped on-time for the code presented right now.
    always_comb begin
        excess = (32'(code) > 32'(KNEE)) ? (32'(code) - 32'(KNEE)) : 32'd0;
        cut    = excess * 32'(SLOPE);
        if (cut >= 32'(SPAN)) begin
            len_d = LEN_W'(MIN_ON);
        end else begin
            len_d = LEN_W'(32'(MAX_ON) - cut);
        end
    end

    // Hold the on-time for the whole period; reload only at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= LEN_W'(MIN_ON);
        end else if (load) begin
            len_q <= len_d;
        end
    end

    assign on_len = len_q;

    // R6: the latched on-time stays inside [MIN_ON, MAX_ON].
    a_r6_len_window: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(len_q) >= 32'(MIN_ON)) && (32'(len_q) <= 32'(MAX_ON)));

    // R3: away from the boundary the on-time cannot move.
    a_r3_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(len_q));

endmodule

// File: rtl/pwm_gate_latch.sv
// Module: pwm_gate_latch
// Set/reset gate latch. It is set at the period start when the run enable is
// high. It is reset when the pulse length is reached, when the run enable
// drops, or when the current-limit flag arrives after the guard interval.
// Once reset it stays off until the next period start.
// Assumes on_len >= MIN_ON and that phase/wrap come from pwm_sawtooth.
module pwm_gate_latch #(
    parameter int PERIOD = 500,
    parameter int PH_W   = 9,
    parameter int LEN_W  = 9,
    parameter int MIN_ON = 7,
    parameter int BLANK  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PH_W-1:0]  phase,
    input  logic             wrap,
    input  logic [LEN_W-1:0] on_len,
    input  logic             ilim,
    input  logic             run_en,
    output logic             gate
);
    import pwm_pkg::*;

    localparam int GUARD = max_int(BLANK, MIN_ON);
    localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

    logic gate_q;
    logic gate_d;
    logic more_on;
    logic limit_live;

    // The pulse continues while the next phase is still inside the on-time.
    assign more_on    = (int'(phase) + 1) < int'(on_len);
    // The current limit counts only once the guard interval has passed.
    assign limit_live = ilim && (int'(phase) >= GUARD - 1);

    // Next state of the latch: set at the boundary, otherwise it can only clear.
    always_comb begin
        if (wrap) begin
            gate_d = run_en;
        end else begin
            gate_d = gate_q && run_en && more_on && !limit_live;
        end
    end

    // Gate register that drives the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign gate = gate_q;

    // R2: a pulse only begins on phase zero.
    a_r2_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q) |-> (phase == '0));

    // R7: once off inside a period, the gate stays off until the wrap.
    a_r7_stay_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_q && (phase != LAST)) |=> !gate_q);

    // R6: the minimum on-time cannot be cut by the limit flag.
    a_r6_min_on: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && run_en && (int'(phase) < MIN_ON - 1)) |=> gate_q);

    // R8: inside blanking the limit flag cannot end a pulse that has time left.
    a_r8_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && run_en && more_on && (int'(phase) < GUARD - 1)) |=> gate_q);

    // R9: a low run enable forces the gate off on the next clock.
    a_r9_run_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && (phase != LAST)) |=> !gate_q);

endmodule

// File: rtl/pwm_switch_ctrl.sv
// Module: pwm_switch_ctrl (top)
// Fixed-frequency voltage-mode PWM for a power switch. The control code sets
// the on-time through an inverse linear law with a maximum-duty clamp and a
// minimum on-time. A blanked current-limit flag and the run enable can cut a
// pulse, and it cannot restart until the next period.
// Assumes CLK_HZ/SW_HZ >= 3 and that MAX_DUTY_PCT gives more clocks than the
// minimum-duty floor.
module pwm_switch_ctrl #(
    parameter int CLK_HZ          = 50_000_000,
    parameter int SW_HZ           = 100_000,
    parameter int CODE_W          = 8,
    parameter int MAX_DUTY_PCT    = 67,
    parameter int MIN_DUTY_PERMIL = 15,
    parameter int KNEE_CODE       = 25,
    parameter int SLOPE_CLKS      = 8,
    parameter int BLANK_CLKS      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ctrl_code,
    input  logic              ilim_trip,
    input  logic              run_en,
    output logic              gate_drv,
    output logic              cycle_end
);
    import pwm_pkg::*;

    localparam int PERIOD = CLK_HZ / SW_HZ;
    localparam int PH_W   = $clog2(PERIOD);
    localparam int LEN_W  = $clog2(PERIOD + 1);
    localparam int MAX_ON = scale_frac(PERIOD, MAX_DUTY_PCT, 100);
    localparam int MIN_ON = max_int(scale_frac(PERIOD, MIN_DUTY_PERMIL, 1000), 1);

    logic [PH_W-1:0]  phase;
    logic             wrap;
    logic [LEN_W-1:0] on_len;

    // Sawtooth phase and end-of-period strobe.
    pwm_sawtooth #(
        .PERIOD (PERIOD),
        .PH_W   (PH_W)
    ) u_saw (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (phase),
        .wrap        (wrap),
        .last_strobe (cycle_end)
    );

    // Control-to-on-time law, latched at each period start.
    pwm_duty_law #(
        .CODE_W (CODE_W),
        .MAX_ON (MAX_ON),
        .MIN_ON (MIN_ON),
        .KNEE   (KNEE_CODE),
        .SLOPE  (SLOPE_CLKS),
        .LEN_W  (LEN_W)
    ) u_law (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (wrap),
        .code   (ctrl_code),
        .on_len (on_len)
    );

    // Gate set/reset latch with blanking and run control.
    pwm_gate_latch #(
        .PERIOD (PERIOD),
        .PH_W   (PH_W),
        .LEN_W  (LEN_W),
        .MIN_ON (MIN_ON),
        .BLANK  (BLANK_CLKS)
    ) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase  (phase),
        .wrap   (wrap),
        .on_len (on_len),
        .ilim   (ilim_trip),
        .run_en (run_en),
        .gate   (gate_drv)
    );

    // R1: the gate is never high on the strobe clock.
    a_r1_gate_low_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |-> !gate_drv);

endmodule

// File: tb/sim_pwm_switch_ctrl.sv
// Scoreboard bench: a driver queues the expected pulse length for each period;
// a monitor measures every period between strobes and compares.
module sim_pwm_switch_ctrl;
    localparam int P      = 500;
    localparam int CODE_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CODE_W-1:0] ctrl_code = '0;
    logic              ilim_trip = 1'b0;
    logic              run_en = 1'b0;
    logic              gate_drv;
    logic              cycle_end;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        int    len;
        string tag;
    } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    pwm_switch_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_code (ctrl_code),
        .ilim_trip (ilim_trip),
        .run_en    (run_en),
        .gate_drv  (gate_drv),
        .cycle_end (cycle_end)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: called just before the wrap edge; runs one full period.
    task automatic drive_cycle(input int code, input bit run0,
                               input int cl_from, input int cl_to,
                               input int en_off, input int en_on,
                               input int mid_at, input int mid_code,
                               input int exp, input string tag);
        item_t it;
        it.len = exp;
        it.tag = tag;
        exp_q.push_back(it);
        ctrl_code = CODE_W'(code);
        run_en    = run0;
        ilim_trip = 1'b0;
        for (int p = 0; p < P - 1; p++) begin
            @(negedge clk);
            ilim_trip = (p >= cl_from) && (p <= cl_to);
            if (p == en_off) run_en = 1'b0;
            if (p == en_on) run_en = 1'b1;
            if (p == mid_at) ctrl_code = CODE_W'(mid_code);
        end
        @(negedge clk);
    endtask

    // Monitor: measure pulse length, start phase and strobe position per period.
    int  mon_ph = 0;
    int  hi_cnt = 0;
    int  rises = 0;
    bit  prev_gate = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            mon_ph = 0; hi_cnt = 0; rises = 0; prev_gate = 1'b0;
        end else begin
            if (gate_drv && !prev_gate) begin
                rises++;
                if (mon_ph != 0 || rises > 1)
                    check(1'b0, "R2 rise position", mon_ph, 0);
            end
            if (gate_drv) hi_cnt++;
            if (cycle_end && mon_ph != P - 1)
                check(1'b0, "R1 strobe phase", mon_ph, P - 1);
            if (mon_ph == P - 1) begin
                check(cycle_end == 1'b1, "R1 strobe present", int'(cycle_end), 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected period", hi_cnt, -1);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(hi_cnt == it.len, it.tag, hi_cnt, it.len);
                end
                hi_cnt = 0; rises = 0; mon_ph = 0;
            end else begin
                mon_ph++;
            end
            prev_gate = gate_drv;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs are low while reset is held.
        check(gate_drv == 1'b0, "R1 reset gate", int'(gate_drv), 0);
        check(cycle_end == 1'b0, "R1 reset strobe", int'(cycle_end), 0);
        ctrl_code = '0;
        run_en    = 1'b1;
        @(negedge clk);
        #2 rst_n = 1'b1;

        drive_cycle(0,   1, -1, -2, -1, -1, -1, 0, 335, "R4 code 0");
        drive_cycle(25,  1, -1, -2, -1, -1, -1, 0, 335, "R4 code at knee");
        drive_cycle(26,  1, -1, -2, -1, -1, -1, 0, 327, "R5 code 26");
        drive_cycle(50,  1, -1, -2, -1, -1, -1, 0, 135, "R5 code 50");
        drive_cycle(66,  1, -1, -2, -1, -1, -1, 0, 7,   "R6 code 66 floor");
        drive_cycle(255, 1, -1, -2, -1, -1, -1, 0, 7,   "R6 code 255 floor");
        drive_cycle(0,   1, 0, P, -1, -1, -1, 0, 10,    "R8 limit held all period");
        drive_cycle(0,   1, 3, 5, -1, -1, -1, 0, 335,   "R8 limit inside blanking ignored");
        drive_cycle(0,   1, 50, 50, -1, -1, -1, 0, 51,  "R7 limit at 50 then off");
        drive_cycle(66,  1, 0, P, -1, -1, -1, 0, 7,     "R8 limit with floor length");
        drive_cycle(0,   1, -1, -2, -1, -1, 50, 200, 335, "R3 mid-period code change");
        drive_cycle(200, 1, -1, -2, -1, -1, -1, 0, 7,   "R3 new code next period");
        drive_cycle(0,   0, -1, -2, -1, -1, -1, 0, 0,   "R9 run low at start");
        drive_cycle(0,   1, -1, -2, 100, 150, -1, 0, 101, "R9 run drop at 100");
        drive_cycle(26,  1, -1, -2, -1, -1, -1, 0, 327, "R9 re-enable next period");

        @(negedge clk);
        check(exp_q.size() == 0, "R1 all periods seen", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule